// File: doc/BRIEF.md
# Banked Masked Control Register File

This block holds the system-control state of a multithreaded processor core. Each entry is named by a register number and a select value, folded into one flat index. An entry is stored in one of three ways: one copy for the whole core, one copy per virtual processing element (VPE), or one copy per hardware thread. The requesting thread ID picks the copy. For a per-VPE entry, the thread's binding register names the VPE.

Software writes go through a write mask that belongs to each stored copy. Bits outside the mask keep their stored value, so read-only fields survive. A separate privileged port writes a value, a mask, or both straight into any copy with no filtering. Reads are combinational and return both the stored value and its mask. Each accepted filtered write raises a one-cycle strobe, which lets neighbouring logic react to a change in control state.

Top module: `ctlreg_file`

## Requirements
- R1: The flat index is 8 × register + select and covers entries 0 to 256. A read at index 257 or above returns zero for both value and mask. A filtered or direct write at such an index changes nothing and raises no strobe.
- R2: The following entries hold one copy per thread, selected by the requesting thread ID: 17 to 23, 96, 136 and 184.
- R3: The following entries hold one copy per VPE: 9 to 15, 49 to 53 and 121. The copy is chosen by bits [3:0] of the requesting thread's own copy of entry 18, the binding register. A binding value of NUM_VPES or more selects VPE copy 0.
- R4: Every other entry in range has a single copy that all threads share.
- R5: A filtered write stores (wdata AND mask) OR (old AND NOT mask), using the mask of the addressed copy.
- R6: `sw_done` is high in the cycle after an accepted filtered write and low otherwise.
- R7: A direct value write stores the full data word. When a direct value write and a filtered write hit the same copy in the same cycle, the direct value is the one stored.
- R8: A direct mask write replaces the mask of the addressed copy only. The new mask then governs later filtered writes to that copy.
- R9: At reset every value is zero, with three exceptions. Entry 96 reads 0x00400004 in every thread copy. Entry 8 reads 63. Entry 121 reads 0x80000000 in every VPE copy.
- R10: At reset the masks are as follows. Entry 96 has 0xFF78FF17, entry 104 has 0x08C00300, entry 128 has 0x7FFF0007 and entry 121 has 0x3FFFF000. Entry 0 has 0x7FFFFFFF, entries 16 and 24 have 0x3FFFFFFF, and entry 40 has 0x1FFFF800. Entries 8, 64, 120, 129, 131 and 136 have a mask of zero. All other masks are all-ones.
- R11: A read reflects `rd_tid` and `rd_idx` in the same cycle. A write becomes visible right after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_tid | input | TW | Thread issuing the read |
| rd_idx | input | 9 | Flat index to read |
| rd_data | output | 32 | Stored value of the selected copy |
| rd_mask | output | 32 | Write mask of the selected copy |
| sw_we | input | 1 | Filtered write request |
| sw_tid | input | TW | Thread issuing the filtered write |
| sw_idx | input | 9 | Flat index of the filtered write |
| sw_wdata | input | 32 | Filtered write data |
| sw_done | output | 1 | One-cycle strobe after an accepted filtered write |
| dir_val_we | input | 1 | Direct value write enable |
| dir_mask_we | input | 1 | Direct mask write enable |
| dir_tid | input | TW | Thread whose bank the direct port addresses |
| dir_idx | input | 9 | Flat index for the direct port |
| dir_wdata | input | 32 | Data for a direct value or mask write |

## Verification
The bench builds the block with two threads and two VPEs. This small configuration makes every flat index and every stored copy reachable in a full sweep of reads and writes from both threads. With two VPEs, the binding register can point a thread at either VPE copy, or at an out-of-range VPE that must fall back to copy 0. The sweeps write pseudo-random patterns into the binding register itself, so the copy selection shifts as the sweep runs. The bench model has to follow that shift entry by entry.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int DW        = 32;
  localparam int IDX_W     = 9;
  localparam int ENTRIES   = 257;
  localparam int THR_SLOTS = 10;
  localparam int VPE_SLOTS = 13;
  localparam int BIND_IDX  = 18;
  localparam int BIND_W    = 4;

  // slot within the per-thread group, -1 when not per-thread
  function automatic int thread_slot(input int idx);
    if (idx >= 17 && idx <= 23) return idx - 17;
    case (idx)
      96:      return 7;
      184:     return 8;
      136:     return 9;
      default: return -1;
    endcase
  endfunction

  function automatic int vpe_slot(input int idx);
    if (idx >= 9 && idx <= 15) return idx - 9;
    if (idx >= 49 && idx <= 53) return idx - 42;
    if (idx == 121) return 12;
    return -1;
  endfunction

  function automatic int thread_entry(input int slot);
    if (slot <= 6) return slot + 17;
    case (slot)
      7:       return 96;
      8:       return 184;
      default: return 136;
    endcase
  endfunction

  function automatic int vpe_entry(input int slot);
    if (slot <= 6) return slot + 9;
    if (slot <= 11) return slot + 42;
    return 121;
  endfunction

  // storage word -> flat index, for reset values
  function automatic int word_entry(input int w, input int nt, input int nv);
    int a;
    if (w < ENTRIES) return w;
    a = w - ENTRIES;
    if (a < THR_SLOTS * nt) return thread_entry(a / nt);
    a = a - THR_SLOTS * nt;
    return vpe_entry(a / nv);
  endfunction

  function automatic logic [DW-1:0] reset_value(input int idx);
    case (idx)
      96:      return 32'h0040_0004;
      8:       return 32'd63;
      121:     return 32'h8000_0000;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_mask(input int idx);
    case (idx)
      96:      return 32'hFF78_FF17;
      104:     return 32'h08C0_0300;
      128:     return 32'h7FFF_0007;
      121:     return 32'h3FFF_F000;
      0:       return 32'h7FFF_FFFF;
      16, 24:  return 32'h3FFF_FFFF;
      40:      return 32'h1FFF_F800;
      8, 64, 120, 129, 131, 136: return '0;
      default: return '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] wd,
                                         input logic [DW-1:0] cur,
                                         input logic [DW-1:0] m);
    return (wd & m) | (cur & ~m);
  endfunction
endpackage

// File: rtl/ctlreg_locate.sv
module ctlreg_locate
  import ctlreg_pkg::*;
#(
  parameter int NT = 4,
  parameter int NV = 2,
  parameter int TW = 2,
  parameter int AW = 9
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [TW-1:0]     tid,
  input  logic [BIND_W-1:0] bind_vpe [NT],
  output logic [AW-1:0]     addr,
  output logic              hit
);
  localparam int VPE_BASE = ENTRIES + THR_SLOTS * NT;

  int ts, vs, vi;
  logic [BIND_W-1:0] vraw;

  always_comb begin
    ts   = thread_slot(int'(idx));
    vs   = vpe_slot(int'(idx));
    vraw = (int'(tid) < NT) ? bind_vpe[int'(tid)] : '0;
    vi   = (int'(vraw) < NV) ? int'(vraw) : 0;
    hit  = (int'(idx) < ENTRIES) && (int'(tid) < NT);
    if (ts >= 0)      addr = AW'(ENTRIES + ts * NT + int'(tid));
    else if (vs >= 0) addr = AW'(VPE_BASE + vs * NV + vi);
    else              addr = AW'(idx);
  end
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int NT    = 4,
  parameter int NV    = 2,
  parameter int WORDS = 323,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_fire,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_data,
  input  logic          dv_fire,
  input  logic [AW-1:0] dv_addr,
  input  logic          dm_fire,
  input  logic [AW-1:0] dm_addr,
  input  logic [DW-1:0] dir_data,
  output logic [DW-1:0] vals [WORDS],
  output logic [DW-1:0] msks [WORDS]
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int E = word_entry(w, NT, NV);
    logic [DW-1:0] val_q, msk_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q <= reset_value(E);
        msk_q <= reset_mask(E);
      end else begin
        if (dv_fire && int'(dv_addr) == w)      val_q <= dir_data;
        else if (sw_fire && int'(sw_addr) == w) val_q <= merge(sw_data, val_q, msk_q);
        if (dm_fire && int'(dm_addr) == w)      msk_q <= dir_data;
      end
    end
    assign vals[w] = val_q;
    assign msks[w] = msk_q;
  end
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_VPES    = 2,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    rd_tid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    rd_mask,
  input  logic             sw_we,
  input  logic [TW-1:0]    sw_tid,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [DW-1:0]    sw_wdata,
  output logic             sw_done,
  input  logic             dir_val_we,
  input  logic             dir_mask_we,
  input  logic [TW-1:0]    dir_tid,
  input  logic [IDX_W-1:0] dir_idx,
  input  logic [DW-1:0]    dir_wdata
);
  localparam int WORDS = ENTRIES + THR_SLOTS * NUM_THREADS + VPE_SLOTS * NUM_VPES;
  localparam int AW    = $clog2(WORDS);
  localparam int BIND_WORD0 = ENTRIES + thread_slot(BIND_IDX) * NUM_THREADS;

  logic [DW-1:0]     vals [WORDS];
  logic [DW-1:0]     msks [WORDS];
  logic [BIND_W-1:0] bind_vpe [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bind
    assign bind_vpe[t] = vals[BIND_WORD0 + t][BIND_W-1:0];
  end

  logic [AW-1:0] rd_addr, sw_addr, dir_addr;
  logic          rd_hit, sw_hit, dir_hit;

  ctlreg_locate #(.NT(NUM_THREADS), .NV(NUM_VPES), .TW(TW), .AW(AW)) u_loc_rd (
    .idx(rd_idx), .tid(rd_tid), .bind_vpe(bind_vpe), .addr(rd_addr), .hit(rd_hit));
  ctlreg_locate #(.NT(NUM_THREADS), .NV(NUM_VPES), .TW(TW), .AW(AW)) u_loc_sw (
    .idx(sw_idx), .tid(sw_tid), .bind_vpe(bind_vpe), .addr(sw_addr), .hit(sw_hit));
  ctlreg_locate #(.NT(NUM_THREADS), .NV(NUM_VPES), .TW(TW), .AW(AW)) u_loc_dir (
    .idx(dir_idx), .tid(dir_tid), .bind_vpe(bind_vpe), .addr(dir_addr), .hit(dir_hit));

  // named events for the checker
  logic sw_fire, dv_fire, dm_fire;
  assign sw_fire = sw_we && sw_hit;
  assign dv_fire = dir_val_we && dir_hit;
  assign dm_fire = dir_mask_we && dir_hit;

  ctlreg_store #(.NT(NUM_THREADS), .NV(NUM_VPES), .WORDS(WORDS), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sw_fire(sw_fire), .sw_addr(sw_addr), .sw_data(sw_wdata),
    .dv_fire(dv_fire), .dv_addr(dir_addr),
    .dm_fire(dm_fire), .dm_addr(dir_addr), .dir_data(dir_wdata),
    .vals(vals), .msks(msks));

  assign rd_data = rd_hit ? vals[rd_addr] : '0;
  assign rd_mask = rd_hit ? msks[rd_addr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sw_done <= 1'b0;
    else        sw_done <= sw_fire;
  end
endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk
  import ctlreg_pkg::*;
#(
  parameter int WORDS = 323,
  parameter int AW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_fire,
  input logic [AW-1:0]    sw_addr,
  input logic             dv_fire,
  input logic             dm_fire,
  input logic [AW-1:0]    dir_addr,
  input logic [DW-1:0]    dir_wdata,
  input logic [IDX_W-1:0] rd_idx,
  input logic [DW-1:0]    rd_data,
  input logic [DW-1:0]    rd_mask,
  input logic             sw_done,
  input logic [DW-1:0]    vals [WORDS],
  input logic [DW-1:0]    msks [WORDS]
);
  logic dir_same;
  assign dir_same = dv_fire && (dir_addr == sw_addr);

  // R1
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= ENTRIES) |-> (rd_data == '0 && rd_mask == '0));

  // R6
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> sw_done);

  // R6
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_fire |=> !sw_done);

  // R5
  locked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fire && !dir_same) |=>
      (((vals[$past(sw_addr)] ^ $past(vals[sw_addr])) & ~$past(msks[sw_addr])) == '0));

  // R7
  direct_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dv_fire |=> (vals[$past(dir_addr)] == $past(dir_wdata)));

  // R8
  direct_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_fire |=> (msks[$past(dir_addr)] == $past(dir_wdata)));
endmodule

bind ctlreg_file ctlreg_file_chk #(.WORDS(WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_fire(sw_fire), .sw_addr(sw_addr),
  .dv_fire(dv_fire), .dm_fire(dm_fire), .dir_addr(dir_addr), .dir_wdata(dir_wdata),
  .rd_idx(rd_idx), .rd_data(rd_data), .rd_mask(rd_mask), .sw_done(sw_done),
  .vals(vals), .msks(msks));

// File: tb/ctlreg_file_test.sv
`timescale 1ns/1ps
module ctlreg_file_test;
  localparam int NT = 2;
  localparam int NV = 2;
  localparam int N  = 257;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [0:0]  rd_tid = 0, sw_tid = 0, dir_tid = 0;
  logic [8:0]  rd_idx = 0, sw_idx = 0, dir_idx = 0;
  logic [31:0] rd_data, rd_mask, sw_wdata = 0, dir_wdata = 0;
  logic        sw_we = 0, dir_val_we = 0, dir_mask_we = 0, sw_done;

  always #2 clk = ~clk;

  ctlreg_file #(.NUM_THREADS(NT), .NUM_VPES(NV)) uut (
    .clk(clk), .rst_n(rst_n), .rd_tid(rd_tid), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_mask(rd_mask), .sw_we(sw_we), .sw_tid(sw_tid),
    .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_done(sw_done),
    .dir_val_we(dir_val_we), .dir_mask_we(dir_mask_we), .dir_tid(dir_tid),
    .dir_idx(dir_idx), .dir_wdata(dir_wdata));

  int total = 0, bad = 0;
  logic [31:0] mv [N][2];
  logic [31:0] mm [N][2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 shared, 1 per thread, 2 per VPE
  function automatic int kind(input int i);
    if ((i >= 17 && i <= 23) || i == 96 || i == 136 || i == 184) return 1;
    if ((i >= 9 && i <= 15) || (i >= 49 && i <= 53) || i == 121) return 2;
    return 0;
  endfunction

  function automatic int bank(input int i, input int t);
    int b;
    if (kind(i) == 1) return t;
    if (kind(i) == 0) return 0;
    b = int'(mv[18][t][3:0]);
    return (b >= NV) ? 0 : b;
  endfunction

  task automatic model_init();
    for (int i = 0; i < N; i++)
      for (int b = 0; b < 2; b++) begin
        mv[i][b] = (i == 96) ? 32'h0040_0004 : (i == 8) ? 32'd63 :
                   (i == 121) ? 32'h8000_0000 : 32'h0;
        case (i)
          96: mm[i][b] = 32'hFF78_FF17;
          104: mm[i][b] = 32'h08C0_0300;
          128: mm[i][b] = 32'h7FFF_0007;
          121: mm[i][b] = 32'h3FFF_F000;
          0: mm[i][b] = 32'h7FFF_FFFF;
          16, 24: mm[i][b] = 32'h3FFF_FFFF;
          40: mm[i][b] = 32'h1FFF_F800;
          8, 64, 120, 129, 131, 136: mm[i][b] = 32'h0;
          default: mm[i][b] = 32'hFFFF_FFFF;
        endcase
      end
  endtask

  task automatic check_read(input int t, input int i, input string req);
    logic [31:0] ev, em;
    rd_tid = 1'(t); rd_idx = 9'(i);
    #0.2;
    ev = (i < N) ? mv[i][bank(i, t)] : 32'h0;
    em = (i < N) ? mm[i][bank(i, t)] : 32'h0;
    chk(rd_data === ev, {req, " value"}, rd_data, ev);
    chk(rd_mask === em, {req, " mask"}, rd_mask, em);
  endtask

  task automatic do_sw(input int t, input int i, input logic [31:0] d);
    int b;
    logic [31:0] cur;
    @(negedge clk);
    sw_we = 1; sw_tid = 1'(t); sw_idx = 9'(i); sw_wdata = d;
    if (i < N) begin
      b = bank(i, t);
      cur = mv[i][b];
      mv[i][b] = cur ^ ((cur ^ d) & mm[i][b]);
    end
    @(negedge clk);
    sw_we = 0;
    // R6 strobe one cycle after, none when out of range (R1)
    chk(sw_done === (i < N), "R6 strobe", 32'(sw_done), 32'(i < N));
  endtask

  task automatic do_dir(input bit vw, input bit mw, input int t, input int i,
                        input logic [31:0] d);
    int b;
    @(negedge clk);
    dir_val_we = vw; dir_mask_we = mw; dir_tid = 1'(t); dir_idx = 9'(i); dir_wdata = d;
    if (i < N) begin
      b = bank(i, t);
      if (vw) mv[i][b] = d;
      if (mw) mm[i][b] = d;
    end
    @(negedge clk);
    dir_val_we = 0; dir_mask_we = 0;
  endtask

  task automatic sweep_read(input string req);
    for (int i = 0; i < N; i++)
      for (int t = 0; t < NT; t++) check_read(t, i, req);
  endtask

  bit finished = 0;

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 R10 reset state of every copy
    sweep_read("R9/R10 reset");
    chk(sw_done === 1'b0, "R6 idle", 32'(sw_done), 0);

    // R5 R2 R3 R4 filtered sweep from thread 1 (binding moves with it)
    for (int i = 0; i < N; i++) do_sw(1, i, (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0000);
    sweep_read("R5 sweep t1");
    for (int i = 0; i < N; i++) do_sw(0, i, ~(32'(i) * 32'h0101_7F3D));
    sweep_read("R5 sweep t0");

    // R3 bind thread 1 to VPE 1, thread 0 to VPE 0
    do_dir(1, 0, 1, 18, 32'h1);
    do_dir(1, 0, 0, 18, 32'h0);
    do_sw(1, 121, 32'hFFFF_FFFF);
    do_sw(0, 9, 32'hCAFE_0001);
    do_sw(1, 9, 32'hBEEF_0002);
    check_read(0, 121, "R3 vpe0");
    check_read(1, 121, "R3 vpe1");
    check_read(0, 9, "R3 vpe0 idx9");
    check_read(1, 9, "R3 vpe1 idx9");
    // R3 out-of-range binding falls back to VPE 0
    do_dir(1, 0, 1, 18, 32'h7);
    check_read(1, 9, "R3 fallback");
    // R2 per-thread isolation
    do_sw(0, 96, 32'h0000_FFFF);
    check_read(1, 96, "R2 t1 untouched");
    check_read(0, 96, "R2 t0");
    // R4 shared entry seen by both
    do_sw(1, 72, 32'h1357_9BDF);
    check_read(0, 72, "R4 shared");

    // R7 direct value into read-only entry
    do_dir(1, 0, 0, 120, 32'h1234_5678);
    check_read(1, 120, "R7 direct value");
    // R7 direct beats filtered in same cycle
    @(negedge clk);
    dir_val_we = 1; dir_tid = 0; dir_idx = 9'd64; dir_wdata = 32'hA0A0_A0A0;
    sw_we = 1; sw_tid = 0; sw_idx = 9'd64; sw_wdata = 32'h0505_0505;
    mv[64][0] = 32'hA0A0_A0A0;
    @(negedge clk);
    dir_val_we = 0; sw_we = 0;
    check_read(0, 64, "R7 priority");

    // R8 direct mask then filtered write governed by it
    do_dir(0, 1, 0, 8, 32'hFFFF_0000);
    do_sw(0, 8, 32'h8765_4321);
    check_read(0, 8, "R8 new mask");
    do_dir(0, 1, 1, 23, 32'h0000_00FF);
    check_read(0, 23, "R8 other copy mask");
    check_read(1, 23, "R8 this copy mask");

    // R1 out of range
    do_sw(0, 300, 32'hFFFF_FFFF);
    do_dir(1, 1, 0, 400, 32'hFFFF_FFFF);
    check_read(0, 300, "R1 oor");
    check_read(1, 511, "R1 oor");
    // R11 final full sweep: nothing else disturbed
    sweep_read("R11 final");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule